// File: doc/BRIEF.md
# Indirect Window Memory Read Bridge

This block gives a host with a narrow, byte-wide register port read access to a wide internal 32-bit address space. The host builds a 32-bit window address one byte at a time in an address register. Writing its lowest byte launches a read of the addressed 32-bit word. When the word comes back, it is latched into a 32-bit data register, which the host reads byte by byte.

The bridge decodes the internal address space itself. The space repeats every 4 MB. A read-only region and a read/write region are forwarded to a memory-side request/acknowledge port. Every other location returns a fixed marker word at once, without any memory access. A busy flag covers the time between launch and data capture. A launch that arrives while busy is held in one slot and issued when the current fetch finishes.

Top module: `winrd_bridge`

## Requirements
- R1: After reset, busy and the memory request are low and all four data register bytes read as zero.
- R2: Writes to address register bytes 1, 2 and 3 (offsets 0x47D, 0x47E, 0x47F; byte k holds address bits 8k+7:8k) only stage the value. No memory request is raised, busy stays low and the data register is unchanged.
- R3: A write to address register byte 0 (offset 0x47C) launches a fetch of the address formed with the staged upper bytes. Busy reads high from the clock edge that takes that write.
- R4: After a fetch, data register byte k (offset 0x474+k) returns bits 8k+7:8k of the fetched word. For a memory region the word is the one at index (offset from the region base)/4, and the region is flagged on the in-RAM output.
- R5: Address bits 1:0 are ignored, so every fetch reads the aligned word.
- R6: Only the low 22 address bits are decoded, so any address reads the same as its image in the first 4 MB.
- R7: Unmapped locations below 0x040000 return 0xDEADC0DE and those at or above it return 0xDEADBEEF. Neither raises a memory request, and busy lasts exactly one cycle.
- R8: The read-only region covers 0x0E0000 to 0x0F3FFF (80 KB) and the read/write region covers 0x100000 to 0x12DFFF (184 KB). The words just past each end read the fill value.
- R9: While busy, the data register keeps returning the previously fetched word.
- R10: A byte-0 write during a fetch is held and issued after the current fetch completes. The final data register holds the later word, and both fetches reach memory.
- R11: Busy stays high from launch until the data register loads. A memory request holds its word stable until acknowledged, so a memory fetch is busy for the acknowledge latency plus one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Byte register write strobe |
| reg_wr_ofs | input | OFS_W | Byte offset of the register write |
| reg_wr_byte | input | 8 | Write data byte |
| reg_rd_ofs | input | OFS_W | Byte offset of the register read |
| reg_rd_byte | output | 8 | Read data byte (combinational) |
| busy | output | 1 | Fetch in progress or held |
| mem_req | output | 1 | Memory-side read request |
| mem_in_ram | output | 1 | Request targets the read/write region (else the read-only one) |
| mem_word | output | MEM_WORD_W | Word index within the selected region |
| mem_ack | input | 1 | Memory acknowledge; data valid in the same cycle |
| mem_rdata | input | 32 | Memory read data |

## Verification
The assertions assume that memory raises its acknowledge only while a request is up, and never in the cycle after it has just acknowledged. The bench memory model meets this by design. Its latency is a counter restarted by each acknowledge, and its data is registered together with the acknowledge. The bench drives register writes one at a time and away from clock edges. It also makes sure the host never writes during reset, which keeps every launch well defined for the assertions.

// File: rtl/winrd_pkg.sv
package winrd_pkg;
   typedef enum logic [1:0] {
      REG_HOLE_LO = 2'd0,
      REG_HOLE_HI = 2'd1,
      REG_ROM     = 2'd2,
      REG_RAM     = 2'd3
   } region_t;

   localparam logic [31:0] FILL_LO = 32'hDEAD_C0DE;
   localparam logic [31:0] FILL_HI = 32'hDEAD_BEEF;
endpackage

// File: rtl/winrd_addr_stage.sv
module winrd_addr_stage #(
   parameter int OFS_W    = 12,
   parameter int ADDR_OFS = 'h47C,
   parameter int LANES    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [OFS_W-1:0] wr_ofs,
   input  logic [7:0]       wr_byte,
   output logic             trig,
   output logic [8*LANES-1:0] trig_addr
);
   logic [LANES-1:0]   hit;
   logic [8*LANES-1:0] stage_q;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign hit[k] = wr_en && (wr_ofs == OFS_W'(ADDR_OFS + k));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_q <= '0;
      end else begin
         for (int k = 0; k < LANES; k++) begin
            if (hit[k]) stage_q[8*k +: 8] <= wr_byte;
         end
      end
   end

   // lane 0 launches; upper lanes only stage
   assign trig      = hit[0];
   assign trig_addr = {stage_q[8*LANES-1:8], wr_byte};

   a_r2_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));
endmodule

// File: rtl/winrd_decode.sv
module winrd_decode
   import winrd_pkg::*;
#(
   parameter int MIRROR_W   = 22,
   parameter int ROM_BASE   = 'h0E0000,
   parameter int ROM_BYTES  = 'h014000,
   parameter int RAM_BASE   = 'h100000,
   parameter int RAM_BYTES  = 'h02E000,
   parameter int HOLE_SPLIT = 'h040000,
   parameter int MEM_WORD_W = 16
) (
   input  logic [31:0]           addr,
   output region_t               region,
   output logic [MEM_WORD_W-1:0] word,
   output logic [31:0]           fill
);
   localparam logic [MIRROR_W-1:0] ROM_LO = MIRROR_W'(ROM_BASE);
   localparam logic [MIRROR_W-1:0] ROM_HI = MIRROR_W'(ROM_BASE + ROM_BYTES);
   localparam logic [MIRROR_W-1:0] RAM_LO = MIRROR_W'(RAM_BASE);
   localparam logic [MIRROR_W-1:0] RAM_HI = MIRROR_W'(RAM_BASE + RAM_BYTES);
   localparam logic [MIRROR_W-1:0] SPLIT  = MIRROR_W'(HOLE_SPLIT);

   logic [MIRROR_W-1:0] a, rom_off, ram_off;

   if (MIRROR_W == 32) begin : g_full
      assign a = addr;
   end else begin : g_mirror
      logic unused_hi;
      assign unused_hi = ^addr[31:MIRROR_W];
      assign a = addr[MIRROR_W-1:0];
   end

   always_comb begin
      rom_off = a - ROM_LO;
      ram_off = a - RAM_LO;
      word    = '0;
      if (a >= ROM_LO && a < ROM_HI) begin
         region = REG_ROM;
         word   = MEM_WORD_W'(rom_off >> 2);
      end else if (a >= RAM_LO && a < RAM_HI) begin
         region = REG_RAM;
         word   = MEM_WORD_W'(ram_off >> 2);
      end else if (a < SPLIT) begin
         region = REG_HOLE_LO;
      end else begin
         region = REG_HOLE_HI;
      end
      fill = (region == REG_HOLE_LO) ? FILL_LO : FILL_HI;
   end

   always_comb begin
      if (region == REG_ROM) a_r8_rom_word: assert (32'(word) < ROM_BYTES / 4);
      if (region == REG_RAM) a_r8_ram_word: assert (32'(word) < RAM_BYTES / 4);
   end
endmodule

// File: rtl/winrd_fetch.sv
module winrd_fetch
   import winrd_pkg::*;
#(
   parameter int MEM_WORD_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  trig,
   input  logic [31:0]           trig_addr,
   input  region_t               region,
   input  logic [MEM_WORD_W-1:0] dec_word,
   input  logic [31:0]           fill,
   input  logic                  mem_ack,
   input  logic [31:0]           mem_rdata,
   output logic [31:0]           cur_addr,
   output logic                  busy,
   output logic                  mem_req,
   output logic                  mem_in_ram,
   output logic [MEM_WORD_W-1:0] mem_word,
   output logic [31:0]           data_q
);
   logic        busy_q, pend_q;
   logic [31:0] cur_q, pend_addr_q;
   logic        is_hole, done;

   assign is_hole = (region == REG_HOLE_LO) || (region == REG_HOLE_HI);
   assign done    = busy_q && (is_hole || mem_ack);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         pend_q      <= 1'b0;
         cur_q       <= '0;
         pend_addr_q <= '0;
         data_q      <= '0;
      end else begin
         if (done) data_q <= is_hole ? fill : mem_rdata;
         if (!busy_q) begin
            if (trig) begin
               busy_q <= 1'b1;
               cur_q  <= trig_addr;
            end
         end else if (done) begin
            if (pend_q) begin
               cur_q <= pend_addr_q;
               if (trig) pend_addr_q <= trig_addr;
               else      pend_q      <= 1'b0;
            end else if (trig) begin
               cur_q <= trig_addr;
            end else begin
               busy_q <= 1'b0;
            end
         end else if (trig) begin
            pend_q      <= 1'b1;
            pend_addr_q <= trig_addr;
         end
      end
   end

   assign cur_addr   = cur_q;
   assign busy       = busy_q;
   assign mem_req    = busy_q && !is_hole;
   assign mem_in_ram = (region == REG_RAM);
   assign mem_word   = dec_word;

   a_r11_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !done |=> busy_q);
   a_r9_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !done |=> $stable(data_q));
   a_r11_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_word) && $stable(mem_in_ram));
   a_r10_pend_busy: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> busy_q);
   a_r2_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q && !trig |=> !busy_q);
   a_r4_ack_on_req: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ack |-> mem_req);
endmodule

// File: rtl/winrd_bridge.sv
module winrd_bridge
   import winrd_pkg::*;
#(
   parameter int OFS_W      = 12,
   parameter int ADDR_OFS   = 'h47C,
   parameter int DATA_OFS   = 'h474,
   parameter int MIRROR_W   = 22,
   parameter int ROM_BASE   = 'h0E0000,
   parameter int ROM_BYTES  = 'h014000,
   parameter int RAM_BASE   = 'h100000,
   parameter int RAM_BYTES  = 'h02E000,
   parameter int HOLE_SPLIT = 'h040000,
   parameter int MEM_WORD_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr_en,
   input  logic [OFS_W-1:0]      reg_wr_ofs,
   input  logic [7:0]            reg_wr_byte,
   input  logic [OFS_W-1:0]      reg_rd_ofs,
   output logic [7:0]            reg_rd_byte,
   output logic                  busy,
   output logic                  mem_req,
   output logic                  mem_in_ram,
   output logic [MEM_WORD_W-1:0] mem_word,
   input  logic                  mem_ack,
   input  logic [31:0]           mem_rdata
);
   localparam int LANES     = 4;
   localparam int ROM_WORDS = ROM_BYTES / 4;
   localparam int RAM_WORDS = RAM_BYTES / 4;

   if ((ROM_BYTES % 4) != 0 || (RAM_BYTES % 4) != 0) begin : g_bad_align
      $error("region sizes must be whole words");
   end
   if (ROM_WORDS > (1 << MEM_WORD_W) || RAM_WORDS > (1 << MEM_WORD_W)) begin : g_bad_word
      $error("MEM_WORD_W too narrow for a region");
   end
   if (MIRROR_W < 2 || MIRROR_W > 32) begin : g_bad_mirror
      $error("MIRROR_W out of range");
   end
   if (ROM_BASE + ROM_BYTES > RAM_BASE) begin : g_bad_order
      $error("read-only region must lie below read/write region");
   end

   logic        trig;
   logic [31:0] trig_addr, cur_addr, fill, data_q;
   region_t     region;
   logic [MEM_WORD_W-1:0] dec_word;

   winrd_addr_stage #(.OFS_W(OFS_W), .ADDR_OFS(ADDR_OFS), .LANES(LANES)) u_stage (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_ofs(reg_wr_ofs),
      .wr_byte(reg_wr_byte), .trig(trig), .trig_addr(trig_addr));

   winrd_decode #(
      .MIRROR_W(MIRROR_W), .ROM_BASE(ROM_BASE), .ROM_BYTES(ROM_BYTES),
      .RAM_BASE(RAM_BASE), .RAM_BYTES(RAM_BYTES), .HOLE_SPLIT(HOLE_SPLIT),
      .MEM_WORD_W(MEM_WORD_W)) u_dec (
      .addr(cur_addr), .region(region), .word(dec_word), .fill(fill));

   winrd_fetch #(.MEM_WORD_W(MEM_WORD_W)) u_fetch (
      .clk(clk), .rst_n(rst_n), .trig(trig), .trig_addr(trig_addr),
      .region(region), .dec_word(dec_word), .fill(fill),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .cur_addr(cur_addr),
      .busy(busy), .mem_req(mem_req), .mem_in_ram(mem_in_ram),
      .mem_word(mem_word), .data_q(data_q));

   always_comb begin
      reg_rd_byte = '0;
      for (int k = 0; k < LANES; k++) begin
         if (reg_rd_ofs == OFS_W'(DATA_OFS + k)) reg_rd_byte = data_q[8*k +: 8];
      end
   end

   a_r1_no_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);
endmodule

// File: tb/winrd_bridge_tb_top.sv
module winrd_bridge_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [11:0] reg_wr_ofs = '0;
   logic [7:0]  reg_wr_byte = '0;
   logic [11:0] reg_rd_ofs = 12'h474;
   logic [7:0]  reg_rd_byte;
   logic        busy, mem_req, mem_in_ram, mem_ack;
   logic [15:0] mem_word;
   logic [31:0] mem_rdata;

   int n_checks = 0, n_fail = 0, lat = 3, n_acks = 0, cnt = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   winrd_bridge dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_ofs(reg_wr_ofs),
      .reg_wr_byte(reg_wr_byte), .reg_rd_ofs(reg_rd_ofs), .reg_rd_byte(reg_rd_byte),
      .busy(busy), .mem_req(mem_req), .mem_in_ram(mem_in_ram), .mem_word(mem_word),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata));

   function automatic logic [31:0] mem_val(input logic ram, input logic [15:0] w);
      return {ram ? 16'h7A11 : 16'h0B0B, w};
   endfunction

   // behavioural memory: ack after lat cycles of request
   always_ff @(posedge clk) begin
      if (!rst_n || !mem_req) begin
         mem_ack <= 1'b0; cnt <= 0; mem_rdata <= '0;
      end else if (mem_ack) begin
         mem_ack <= 1'b0; cnt <= 0; n_acks <= n_acks + 1;
      end else if (cnt >= lat - 1) begin
         mem_ack <= 1'b1; mem_rdata <= mem_val(mem_in_ram, mem_word);
      end else begin
         cnt <= cnt + 1;
      end
   end

   // reference model of the address map
   function automatic logic [31:0] exp_word(input logic [31:0] addr);
      int a;
      a = int'(addr & 32'h003F_FFFC);
      if (a >= 'h0E0000 && a < 'h0F4000) return mem_val(1'b0, 16'((a - 'h0E0000) / 4));
      if (a >= 'h100000 && a < 'h12E000) return mem_val(1'b1, 16'((a - 'h100000) / 4));
      if (a < 'h040000) return 32'hDEADC0DE;
      return 32'hDEADBEEF;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] ofs, input logic [7:0] b);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_wr_ofs = ofs; reg_wr_byte = b;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic stage_upper(input logic [31:0] addr);
      wr(12'h47D, addr[15:8]);
      wr(12'h47E, addr[23:16]);
      wr(12'h47F, addr[31:24]);
   endtask

   task automatic read_word(output logic [31:0] w);
      for (int k = 0; k < 4; k++) begin
         reg_rd_ofs = 12'h474 + 12'(k);
         #1;
         w[8*k +: 8] = reg_rd_byte;
      end
      reg_rd_ofs = 12'h474;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy && n < 1000) begin n++; @(negedge clk); end
   endtask

   task automatic fetch_chk(input logic [31:0] addr, input string req);
      logic [31:0] w; int n;
      stage_upper(addr);
      wr(12'h47C, addr[7:0]);
      wait_idle(n);
      read_word(w);
      chk(w == exp_word(addr), req, w, exp_word(addr));
   endtask

   initial begin
      logic [31:0] w, w0; int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      read_word(w);
      chk(!busy && !mem_req, "R1 busy/req", {busy, mem_req}, 0);
      chk(w == 0, "R1 data", w, 0);

      // R2: upper bytes only stage
      stage_upper(32'h000E_0000);
      chk(!busy && !mem_req, "R2 no access", {busy, mem_req}, 0);
      repeat (3) @(negedge clk);
      read_word(w);
      chk(!busy && w == 0, "R2 data unchanged", w, 0);

      // R3 + R11: byte 0 launches; busy lasts lat+1 cycles
      lat = 3;
      wr(12'h47C, 8'h10);
      chk(busy && mem_req, "R3 launch", {busy, mem_req}, 2'b11);
      wait_idle(n);
      chk(n == lat + 1, "R11 busy length", n, lat + 1);
      read_word(w);
      chk(w == exp_word(32'h000E_0010), "R4 rom word", w, exp_word(32'h000E_0010));

      // R4 / R8: regions and bounds
      fetch_chk(32'h0010_0000, "R4 ram first");
      fetch_chk(32'h0010_8A44, "R4 ram middle");
      fetch_chk(32'h000E_0000, "R8 rom first");
      fetch_chk(32'h000F_3FFC, "R8 rom last");
      fetch_chk(32'h000F_4000, "R8 past rom");
      fetch_chk(32'h0012_DFFC, "R8 ram last");
      fetch_chk(32'h0012_E000, "R8 past ram");
      fetch_chk(32'h000D_FFFC, "R8 before rom");

      // R5: low address bits ignored
      fetch_chk(32'h000E_1237, "R5 unaligned rom");
      fetch_chk(32'h0010_0002, "R5 unaligned ram");

      // R6: mirroring
      fetch_chk(32'h004E_0020, "R6 mirror 4MB");
      fetch_chk(32'hFFD0_0040, "R6 mirror top");
      fetch_chk(32'h0040_0000, "R6 mirror zero");

      // R7: fills, one cycle, no request
      stage_upper(32'h0000_0000);
      wr(12'h47C, 8'h00);
      chk(busy && !mem_req, "R7 no request", {busy, mem_req}, 2'b10);
      wait_idle(n);
      chk(n == 1, "R7 one cycle", n, 1);
      read_word(w);
      chk(w == 32'hDEADC0DE, "R7 low fill", w, 32'hDEADC0DE);
      fetch_chk(32'h0003_FFFC, "R7 low edge");
      fetch_chk(32'h0004_0000, "R7 high edge");
      fetch_chk(32'h003F_F000, "R7 high fill");

      // R9: read while busy returns previous word
      lat = 8;
      fetch_chk(32'h0010_0100, "R9 setup");
      read_word(w0);
      stage_upper(32'h000E_0200);
      wr(12'h47C, 8'h00);
      repeat (2) @(negedge clk);
      read_word(w);
      chk(busy && w == w0, "R9 old word while busy", w, w0);
      wait_idle(n);
      read_word(w);
      chk(w == exp_word(32'h000E_0200), "R9 new word", w, exp_word(32'h000E_0200));

      // R10: launch while busy is held and issued
      lat = 12;
      begin
         int acks0;
         acks0 = n_acks;
         stage_upper(32'h0010_0300);
         wr(12'h47C, 8'h00);
         stage_upper(32'h000E_0400);
         wr(12'h47C, 8'h08);
         chk(busy, "R10 still busy at second launch", busy, 1);
         wait_idle(n);
         read_word(w);
         chk(w == exp_word(32'h000E_0408), "R10 held word", w, exp_word(32'h000E_0408));
         chk(n_acks - acks0 == 2, "R10 both fetched", n_acks - acks0, 2);
      end

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      finished = 1;
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule